// File: doc/BRIEF.md
# IN Endpoint Status and Data-Toggle Control

This block is the control and status engine of one non-zero IN endpoint of a USB device controller. Firmware writes two 8-bit registers: a status register that queues packets, requests STALL and clears flags, and a configuration register that picks isochronous or bulk/interrupt operation, automatic packet commit, the toggle advance rule and single or double buffering. The block tracks how many whole packets wait in the endpoint FIFO and answers each IN token with a response code. It keeps the DATA0/DATA1 toggle and pulses flush requests and an endpoint interrupt.

The protocol engine gives an IN-token pulse and waits one cycle for the response. After a data response it reports that the packet went out, and in bulk/interrupt mode it then reports an ACK or a handshake timeout. The FIFO write side reports each byte that firmware stores, so that the block can commit a packet on its own once a full packet has been written. FIFO storage and serialization sit outside the block. The block only issues flush pulses to the FIFO: one that drops the oldest packet and one that drops all of them.

Top module: `in_ep_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the data PID is DATA0 (pid_o=0), and resp_vld_o, flush_one_o, flush_all_o and irq_o are 0.
- R2: A status write with bit 0 set queues one packet. Status bit 0 reads 1 while the queue holds as many packets as it can take: one when config bit 3 is 1, two when it is 0. A queue request made while the queue is full is ignored.
- R3: Status bit 3 (FIFO holds data) goes to 1 when a packet is queued. It returns to 0 when firmware writes 0 to it, and one cycle after the queue becomes empty.
- R4: The cycle after an IN token, resp_vld_o is 1 for one cycle and resp_o carries the answer: 0 data, 1 NAK, 2 STALL, 3 zero-length data. STALL comes first, then data if a packet is queued. An empty queue gives NAK in bulk/interrupt mode (config bit 0 = 0) and zero-length data in isochronous mode (config bit 0 = 1), so NAK never appears in isochronous mode.
- R5: An isochronous IN token that finds the queue empty while no STALL is requested sets status bit 4 (underrun). Writing 0 to that bit clears it.
- R6: While status bit 1 (STALL request) is 1, every IN token is answered with STALL. In that same cycle status bit 2 (STALL sent) goes to 1, flush_all_o pulses, and the queue is emptied, so status bit 0 reads 0. Writing 0 to bit 2 clears it, and writing 0 to bit 1 ends the STALL answers.
- R7: Writing 1 to status bit 6 returns the toggle to DATA0. Status bits 5 and 6 always read 0.
- R8: With config bit 2 at 0, a bulk toggle advances only on an ACK that follows a transmitted packet. A timeout leaves both the toggle and the queued packet unchanged.
- R9: With config bit 2 at 1, a bulk toggle advances on every transmitted packet, whether an ACK or a timeout follows.
- R10: A bulk ACK after a transmitted packet, or an isochronous packet-transmitted pulse, removes one queued packet, and irq_o pulses the following cycle. In isochronous mode pid_o stays 0.
- R11: With config bit 1 at 1, the block queues a packet itself when the bytes written reach the maximum packet size. A size above 1024 counts as 1024, and a size of 0 never queues a packet.
- R12: Writing 1 to status bit 5 drops the oldest queued packet and pulses flush_one_o the following cycle. On an empty queue it gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_we_i | input | 1 | Status register write strobe |
| cfg_we_i | input | 1 | Config register write strobe |
| wdata_i | input | 8 | Register write data |
| max_pkt_i | input | 11 | Maximum packet size in bytes |
| byte_wr_i | input | 1 | One byte written into the endpoint FIFO |
| in_token_i | input | 1 | IN token received, one-cycle pulse |
| pkt_sent_i | input | 1 | Data packet transmitted |
| ack_i | input | 1 | ACK handshake received |
| timeout_i | input | 1 | Handshake wait timed out |
| stat_o | output | 8 | Status register read value |
| cfg_o | output | 8 | Config register read value |
| resp_vld_o | output | 1 | Response code valid |
| resp_o | output | 2 | Response code |
| pid_o | output | 1 | Data PID for the next packet (0 DATA0, 1 DATA1) |
| flush_one_o | output | 1 | Drop oldest FIFO packet |
| flush_all_o | output | 1 | Drop every FIFO packet |
| irq_o | output | 1 | Endpoint interrupt pulse |

## Verification
The assertions check on every cycle that each token gets exactly one response one cycle later, and that a requested STALL wins over all other answers and drops the queue and the ready flag. They also check that a NAK never follows an isochronous configuration, that the two flush pulses never coincide, and that the ACK-only toggle holds still without an ACK. Only the bench scenarios can show the counted behaviour: capacity under single and double buffering, the byte count at which automatic commit fires (including the 1024 clip and the size-0 case), toggle sequences across ACK, timeout and forced advance, and the lag before the data-present flag drops.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
  typedef enum logic [1:0] {
    RESP_DATA  = 2'd0,
    RESP_NAK   = 2'd1,
    RESP_STALL = 2'd2,
    RESP_ZLP   = 2'd3
  } resp_e;

  // status register fields
  localparam int unsigned ST_RDY        = 0;
  localparam int unsigned ST_STALL_REQ  = 1;
  localparam int unsigned ST_STALL_SENT = 2;
  localparam int unsigned ST_NOT_EMPTY  = 3;
  localparam int unsigned ST_UNDERRUN   = 4;
  localparam int unsigned ST_FLUSH      = 5;
  localparam int unsigned ST_CLR_TOG    = 6;

  // config register fields
  localparam int unsigned CF_ISO    = 0;
  localparam int unsigned CF_AUTO   = 1;
  localparam int unsigned CF_FORCE  = 2;
  localparam int unsigned CF_SINGLE = 3;
endpackage

// File: rtl/in_ep_queue.sv
module in_ep_queue #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic drop_i,
  input  logic drop_all_i,
  input  logic single_i,
  output logic full_o,
  output logic empty_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cap;
  logic          add, sub;

  assign cap     = single_i ? CW'(1) : CW'(DEPTH);
  assign full_o  = (cnt_q >= cap);
  assign empty_o = (cnt_q == '0);
  assign add     = commit_i && !full_o;
  assign sub     = drop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (drop_all_i)   cnt_q <= '0;
    else if (add && !sub)  cnt_q <= cnt_q + CW'(1);
    else if (sub && !add)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/in_ep_fill.sv
module in_ep_fill #(
  parameter int unsigned W     = 11,
  parameter int unsigned LIMIT = 1024
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         byte_i,
  input  logic         restart_i,
  input  logic [W-1:0] max_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim   = (max_i > W'(LIMIT)) ? W'(LIMIT) : max_i;
  assign hit_o = en_i && byte_i && (lim != '0) &&
                 (({1'b0, cnt_q} + (W+1)'(1)) == {1'b0, lim});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || hit_o) cnt_q <= '0;
    else if (en_i && byte_i)    cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/in_ep_resp.sv
module in_ep_resp
  import in_ep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  token_i,
  input  logic  stall_req_i,
  input  logic  iso_i,
  input  logic  empty_i,
  output logic  vld_o,
  output resp_e resp_o,
  output logic  stall_go_o,
  output logic  underrun_o
);
  resp_e resp_d;

  assign stall_go_o = token_i && stall_req_i;
  assign underrun_o = token_i && !stall_req_i && iso_i && empty_i;

  always_comb begin
    if (stall_req_i)  resp_d = RESP_STALL;
    else if (!empty_i) resp_d = RESP_DATA;
    else if (iso_i)   resp_d = RESP_ZLP;
    else              resp_d = RESP_NAK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      resp_o <= RESP_DATA;
    end else begin
      vld_o <= token_i;
      if (token_i) resp_o <= resp_d;
    end
  end
endmodule

// File: rtl/in_ep_ctrl.sv
module in_ep_ctrl
  import in_ep_pkg::*;
#(
  parameter int unsigned MAX_PKT_W     = 11,
  parameter int unsigned MAX_PKT_LIMIT = 1024,
  parameter int unsigned QUEUE_DEPTH   = 2,
  parameter int unsigned REG_W         = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stat_we_i,
  input  logic                 cfg_we_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [MAX_PKT_W-1:0] max_pkt_i,
  input  logic                 byte_wr_i,
  input  logic                 in_token_i,
  input  logic                 pkt_sent_i,
  input  logic                 ack_i,
  input  logic                 timeout_i,
  output logic [REG_W-1:0]     stat_o,
  output logic [REG_W-1:0]     cfg_o,
  output logic                 resp_vld_o,
  output logic [1:0]           resp_o,
  output logic                 pid_o,
  output logic                 flush_one_o,
  output logic                 flush_all_o,
  output logic                 irq_o
);
  logic cf_iso, cf_auto, cf_force, cf_single;
  logic stall_req_q, stall_sent_q, not_empty_q, underrun_q;
  logic wait_q, tog_q;
  logic wr_rdy, wr_flush, wr_clr;
  logic fill_hit, commit, consume, tog_adv;
  logic q_full, q_empty, stall_go, underrun_set;
  resp_e resp;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:ST_CLR_TOG+1];

  assign wr_rdy   = stat_we_i && wdata_i[ST_RDY];
  assign wr_flush = stat_we_i && wdata_i[ST_FLUSH];
  assign wr_clr   = stat_we_i && wdata_i[ST_CLR_TOG];
  assign commit   = wr_rdy || fill_hit;
  assign consume  = cf_iso ? pkt_sent_i : (wait_q && ack_i);
  assign tog_adv  = !cf_iso && (cf_force ? pkt_sent_i : (wait_q && ack_i));

  in_ep_fill #(.W(MAX_PKT_W), .LIMIT(MAX_PKT_LIMIT)) u_fill (
    .clk_i, .rst_ni,
    .en_i      (cf_auto),
    .byte_i    (byte_wr_i),
    .restart_i (wr_rdy || stall_go),
    .max_i     (max_pkt_i),
    .hit_o     (fill_hit)
  );

  in_ep_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .commit_i   (commit),
    .drop_i     (consume || wr_flush),
    .drop_all_i (stall_go),
    .single_i   (cf_single),
    .full_o     (q_full),
    .empty_o    (q_empty)
  );

  in_ep_resp u_resp (
    .clk_i, .rst_ni,
    .token_i     (in_token_i),
    .stall_req_i (stall_req_q),
    .iso_i       (cf_iso),
    .empty_i     (q_empty),
    .vld_o       (resp_vld_o),
    .resp_o      (resp),
    .stall_go_o  (stall_go),
    .underrun_o  (underrun_set)
  );
  assign resp_o = resp;

  // configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_iso <= 1'b0; cf_auto <= 1'b0; cf_force <= 1'b0; cf_single <= 1'b0;
    end else if (cfg_we_i) begin
      cf_iso    <= wdata_i[CF_ISO];
      cf_auto   <= wdata_i[CF_AUTO];
      cf_force  <= wdata_i[CF_FORCE];
      cf_single <= wdata_i[CF_SINGLE];
    end
  end

  // status flags: hardware set wins over firmware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_req_q  <= 1'b0;
      stall_sent_q <= 1'b0;
      not_empty_q  <= 1'b0;
      underrun_q   <= 1'b0;
    end else begin
      if (stat_we_i) stall_req_q <= wdata_i[ST_STALL_REQ];

      if (stall_go)                                    stall_sent_q <= 1'b1;
      else if (stat_we_i && !wdata_i[ST_STALL_SENT])   stall_sent_q <= 1'b0;

      if (commit && !q_full && !stall_go)              not_empty_q <= 1'b1;
      else if (q_empty || (stat_we_i && !wdata_i[ST_NOT_EMPTY]))
                                                       not_empty_q <= 1'b0;

      if (underrun_set)                                underrun_q <= 1'b1;
      else if (stat_we_i && !wdata_i[ST_UNDERRUN])     underrun_q <= 1'b0;
    end
  end

  // handshake wait and data toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (stall_go)                 wait_q <= 1'b0;
      else if (pkt_sent_i && !cf_iso) wait_q <= 1'b1;
      else if (ack_i || timeout_i)  wait_q <= 1'b0;

      if (wr_clr)       tog_q <= 1'b0;
      else if (tog_adv) tog_q <= ~tog_q;
    end
  end

  // event pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      flush_one_o <= 1'b0;
      flush_all_o <= 1'b0;
    end else begin
      irq_o       <= consume && !q_empty && !stall_go;
      flush_one_o <= wr_flush && !q_empty && !stall_go;
      flush_all_o <= stall_go;
    end
  end

  assign pid_o = tog_q && !cf_iso;

  always_comb begin
    stat_o                = '0;
    stat_o[ST_RDY]        = q_full;
    stat_o[ST_STALL_REQ]  = stall_req_q;
    stat_o[ST_STALL_SENT] = stall_sent_q;
    stat_o[ST_NOT_EMPTY]  = not_empty_q;
    stat_o[ST_UNDERRUN]   = underrun_q;
    cfg_o                 = '0;
    cfg_o[CF_ISO]         = cf_iso;
    cfg_o[CF_AUTO]        = cf_auto;
    cfg_o[CF_FORCE]       = cf_force;
    cfg_o[CF_SINGLE]      = cf_single;
  end
endmodule

// File: rtl/in_ep_ctrl_chk.sv
module in_ep_ctrl_chk #(
  parameter int unsigned MAX_PKT_W = 11,
  parameter int unsigned REG_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 stat_we_i,
  input logic                 cfg_we_i,
  input logic [REG_W-1:0]     wdata_i,
  input logic [MAX_PKT_W-1:0] max_pkt_i,
  input logic                 byte_wr_i,
  input logic                 in_token_i,
  input logic                 pkt_sent_i,
  input logic                 ack_i,
  input logic                 timeout_i,
  input logic [REG_W-1:0]     stat_o,
  input logic [REG_W-1:0]     cfg_o,
  input logic                 resp_vld_o,
  input logic [1:0]           resp_o,
  input logic                 pid_o,
  input logic                 flush_one_o,
  input logic                 flush_all_o,
  input logic                 irq_o
);
  p_resp_after_token_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_token_i |=> resp_vld_o);

  p_no_spurious_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_token_i |=> !resp_vld_o);

  p_nak_only_bulk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && resp_o == 2'd1) |-> !$past(cfg_o[0]));

  p_stall_drops_queue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && stat_o[1]) |=> (resp_o == 2'd2 && flush_all_o && stat_o[2] && !stat_o[0]));

  p_flush_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_one_o, flush_all_o}));

  p_toggle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_o[2] && !cfg_o[0] && !cfg_we_i && !ack_i && !(stat_we_i && wdata_i[6]))
      |=> $stable(pid_o));
endmodule

bind in_ep_ctrl in_ep_ctrl_chk #(.MAX_PKT_W(MAX_PKT_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/in_ep_ctrl_tb.sv
module in_ep_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_we = 0, cfg_we = 0, byte_wr = 0, in_token = 0;
  logic        pkt_sent = 0, ack = 0, timeout = 0;
  logic [7:0]  wdata = '0;
  logic [10:0] max_pkt = 11'd64;
  logic [7:0]  stat, cfg;
  logic        resp_vld, pid, flush_one, flush_all, irq;
  logic [1:0]  resp;
  int          checks = 0, fails = 0;
  bit          done = 0;

  localparam logic [7:0] KEEP   = 8'h1C;  // leave write-0-clears flags alone
  localparam logic [7:0] QUEUE  = 8'h1D;
  localparam logic [7:0] STALL  = 8'h1E;
  localparam logic [7:0] CLRTOG = 8'h5C;
  localparam logic [7:0] FLUSH  = 8'h3C;

  always #10 clk = ~clk;

  in_ep_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stat_we_i(stat_we), .cfg_we_i(cfg_we),
    .wdata_i(wdata), .max_pkt_i(max_pkt), .byte_wr_i(byte_wr),
    .in_token_i(in_token), .pkt_sent_i(pkt_sent), .ack_i(ack), .timeout_i(timeout),
    .stat_o(stat), .cfg_o(cfg), .resp_vld_o(resp_vld), .resp_o(resp), .pid_o(pid),
    .flush_one_o(flush_one), .flush_all_o(flush_all), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_we = 1; wdata = v; @(negedge clk); stat_we = 0;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1; wdata = v; @(negedge clk); cfg_we = 0;
  endtask

  task automatic token;
    in_token = 1; @(negedge clk); in_token = 0;
  endtask

  task automatic sent;
    pkt_sent = 1; @(negedge clk); pkt_sent = 0;
  endtask

  task automatic give_ack;
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic give_timeout;
    timeout = 1; @(negedge clk); timeout = 0;
  endtask

  task automatic bytes(input int n);
    byte_wr = 1; repeat (n) @(negedge clk); byte_wr = 0;
  endtask

  task automatic t_reset;
    chk(stat, 8'h00, "R1 status after reset");
    chk(cfg, 8'h00, "R1 config after reset");
    chk({resp_vld, pid, flush_one, flush_all, irq}, 5'b0, "R1 outputs after reset");
  endtask

  task automatic t_single;
    wr_cfg(8'h08);
    wr_stat(QUEUE);
    chk(stat, 8'h09, "R2 R3 single queued");
    wr_stat(QUEUE);
    chk(stat[0], 1'b1, "R2 full stays ready");
    token;
    chk({resp_vld, resp}, 3'b100, "R4 data response");
    chk(pid, 1'b0, "R4 first pid");
    sent;
    give_ack;
    chk(irq, 1'b1, "R10 irq after ack");
    chk(pid, 1'b1, "R8 toggle on ack");
    chk(stat[0], 1'b0, "R10 packet consumed");
    idle(1);
    chk(stat[3], 1'b0, "R3 data flag drops after drain");
    chk(irq, 1'b0, "R10 irq is a pulse");
    token;
    chk(resp, 2'd1, "R4 NAK on empty bulk (second commit was ignored, R2)");
  endtask

  task automatic t_double;
    wr_cfg(8'h00);
    wr_stat(CLRTOG);
    chk(pid, 1'b0, "R7 toggle cleared");
    chk(stat[6:5], 2'b00, "R7 self-clearing bits read 0");
    wr_stat(QUEUE);
    chk(stat, 8'h08, "R2 one of two queued");
    wr_stat(QUEUE);
    chk(stat, 8'h09, "R2 two of two queued");
    wr_stat(QUEUE);
    sent; give_ack;
    chk(stat, 8'h08, "R10 one left");
    chk(pid, 1'b1, "R8 toggle after first ack");
    sent; give_ack;
    chk(pid, 1'b0, "R8 toggle after second ack");
    idle(1);
    chk(stat, 8'h00, "R2 third commit was ignored");
    wr_stat(QUEUE);
    wr_stat(8'h14);
    chk(stat[3], 1'b0, "R3 firmware clear of data flag");
    sent; give_ack; idle(1);
  endtask

  task automatic t_timeout;
    wr_cfg(8'h08);
    wr_stat(CLRTOG);
    wr_stat(QUEUE);
    sent;
    give_timeout;
    chk(pid, 1'b0, "R8 timeout holds toggle");
    chk(stat[0], 1'b1, "R8 timeout keeps packet");
    chk(irq, 1'b0, "R8 no irq on timeout");
    sent;
    give_ack;
    chk(pid, 1'b1, "R8 ack advances toggle");
    chk(irq, 1'b1, "R10 irq after retried ack");
    idle(1);
  endtask

  task automatic t_force;
    wr_cfg(8'h0C);
    wr_stat(CLRTOG);
    wr_stat(QUEUE);
    sent;
    chk(pid, 1'b1, "R9 advance on send");
    give_timeout;
    chk(pid, 1'b1, "R9 timeout no extra advance");
    chk(stat[0], 1'b1, "R9 packet still queued");
    sent;
    chk(pid, 1'b0, "R9 advance on resend");
    give_ack;
    chk(pid, 1'b0, "R9 ack no extra advance");
    chk(irq, 1'b1, "R10 irq in forced mode");
    idle(1);
  endtask

  task automatic t_iso;
    wr_cfg(8'h01);
    token;
    chk(resp, 2'd3, "R4 zero-length answer in iso");
    chk(stat[4], 1'b1, "R5 underrun set");
    wr_stat(8'h0C);
    chk(stat[4], 1'b0, "R5 underrun cleared by write 0");
    wr_stat(QUEUE);
    token;
    chk(resp, 2'd0, "R4 iso data");
    chk(stat[4], 1'b0, "R5 no underrun with data");
    chk(pid, 1'b0, "R10 iso pid DATA0");
    sent;
    chk(irq, 1'b1, "R10 iso consume irq");
    idle(1);
    chk(stat, 8'h00, "R10 iso queue empty");
  endtask

  task automatic t_stall;
    wr_cfg(8'h08);
    wr_stat(QUEUE);
    wr_stat(STALL);
    token;
    chk(resp, 2'd2, "R6 STALL answer");
    chk(flush_all, 1'b1, "R6 flush all");
    chk(stat[2:0], 3'b110, "R6 stall sent, ready dropped");
    token;
    chk(resp, 2'd2, "R6 repeated STALL");
    wr_stat(8'h18);
    chk(stat[2:1], 2'b00, "R6 stall flags cleared");
    token;
    chk(resp, 2'd1, "R6 NAK after stall ends");
    chk(flush_all, 1'b0, "R6 no flush without stall");
  endtask

  task automatic t_flush;
    wr_cfg(8'h00);
    wr_stat(QUEUE); wr_stat(QUEUE);
    wr_stat(FLUSH);
    chk(flush_one, 1'b1, "R12 flush pulse");
    chk(stat[0], 1'b0, "R12 one dropped");
    chk(stat[5], 1'b0, "R7 flush bit reads 0");
    wr_stat(FLUSH);
    chk(flush_one, 1'b1, "R12 second flush pulse");
    idle(1);
    wr_stat(FLUSH);
    chk(flush_one, 1'b0, "R12 no pulse when empty");
    token;
    chk(resp, 2'd1, "R12 queue empty after flushes");
  endtask

  task automatic t_autoset;
    wr_cfg(8'h0A);
    max_pkt = 11'd4;
    bytes(3);
    chk(stat[0], 1'b0, "R11 below size");
    bytes(1);
    chk(stat[0], 1'b1, "R11 commit at size");
    sent; give_ack; idle(1);
    max_pkt = 11'd2000;
    bytes(1023);
    chk(stat[0], 1'b0, "R11 clip 1023 bytes");
    bytes(1);
    chk(stat[0], 1'b1, "R11 clip commit at 1024");
    sent; give_ack; idle(1);
    max_pkt = 11'd0;
    bytes(5);
    chk(stat[0], 1'b0, "R11 size 0 never commits");
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset;
    t_single;
    t_double;
    t_timeout;
    t_force;
    t_iso;
    t_stall;
    t_flush;
    t_autoset;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule